// File: doc/BRIEF.md
# Aligned Word Memory with Error Flag

This block is a byte-addressed memory that transfers one 16-bit word per access over a 16-bit address. A small processor uses two copies of it, one to fetch instructions and one for loads and stores. Reads are combinational: with the block enabled and not writing, the output shows the stored word and follows the address as it moves, with no clock involved. Writes are taken at the rising clock edge. Only whole-word transfers exist, and a word access is expected at an even byte address.

An access at an odd address raises `err_o` while the access is in progress. The memory does not reject the access. It drops the lowest address bit, so a misaligned read returns the aligned word that contains the addressed byte, and a misaligned write updates that same word. Each word is held as two byte lanes. The byte at the even address is the upper half of the word and the byte at the odd address is the lower half. Address bits above the configured capacity are ignored, so the contents repeat across the address space.

There is no image loading. When the active-low asynchronous reset is released, the storage is cleared by walking through it one word per clock. `ready_o` goes high when the walk is done. Until then the block ignores accesses. A testbench fills the memory with ordinary writes after `ready_o` is high.

Top module: `aw_mem`

## Requirements
- R1: After `rst_ni` rises, `ready_o` stays low for exactly WORDS rising edges, where WORDS is MEM_BYTES/2, and then stays high until the next reset. While `rst_ni` is low, `ready_o` is low.
- R2: Once `ready_o` rises after a reset, every word reads as zero, whatever was written before the reset.
- R3: With `enable_i` low the block is idle. `data_out_o` is zero, `err_o` is low, and no location changes, even when `wr_i` is high.
- R4: With `enable_i` high, `wr_i` low and `ready_o` high, `data_out_o` equals the word at the aligned address. It follows changes of `addr_i` without any clock edge.
- R5: With `enable_i` and `wr_i` high and `ready_o` high at a rising edge, `data_in_i` is stored at the aligned word. During the write cycle `data_out_o` is zero.
- R6: With `enable_i` high and `ready_o` high, `err_o` equals `addr_i[0]` for both reads and writes.
- R7: A read at an odd address returns the word stored at `addr_i` with bit 0 cleared.
- R8: A write at an odd address updates the word at `addr_i` with bit 0 cleared.
- R9: Address bits at and above log2(MEM_BYTES) are ignored. Addresses A and A + k*MEM_BYTES name the same word.
- R10: While `ready_o` is low, writes are dropped, and `data_out_o` and `err_o` are held at zero whatever the access inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. Writes and clear steps happen on its rising edge. |
| rst_ni | input | 1 | Asynchronous reset, active low. Starts the clear walk. |
| enable_i | input | 1 | Access request. |
| wr_i | input | 1 | Write when high and enabled, read when low and enabled. |
| addr_i | input | ADDR_W (16) | Byte address. |
| data_in_i | input | DATA_W (16) | Write data. |
| data_out_o | output | DATA_W (16) | Read data, combinational. |
| err_o | output | 1 | Misaligned access flag, combinational. |
| ready_o | output | 1 | High once the clear walk has finished. |

## Verification
The bench builds the block with MEM_BYTES = 64, which gives 32 words, and keeps the full 16-bit address. At this size it can write every word, then read back every byte address, even and odd, and compare each word and error flag against a pattern it computes from the word index. The small size also keeps the clear walk to 32 cycles. The bench counts that interval exactly and injects writes partway through it to show they are dropped. High address bits stay wide, so aliasing is exercised at addresses near the top of the 64K space.

// File: rtl/aw_mem_pkg.sv
package aw_mem_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } mem_op_e;

  function automatic mem_op_e op_of(input logic en, input logic wr, input logic rdy);
    if (!en || !rdy) return OP_IDLE;
    return wr ? OP_WRITE : OP_READ;
  endfunction

endpackage

// File: rtl/aw_mem_decode.sv
module aw_mem_decode
  import aw_mem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 10
) (
  input  logic              enable_i,
  input  logic              wr_i,
  input  logic              ready_i,
  input  logic [ADDR_W-1:0] addr_i,
  output mem_op_e           op_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              misalign_o
);

  always_comb begin
    op_o       = op_of(enable_i, wr_i, ready_i);
    // offset bits dropped; bits above capacity ignored (aliasing)
    idx_o      = addr_i[OFF_W +: IDX_W];
    misalign_o = (op_o != OP_IDLE) && (addr_i[OFF_W-1:0] != '0);
  end

endmodule

// File: rtl/aw_mem_clear.sv
module aw_mem_clear #(
  parameter int WORDS = 1024,
  parameter int IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             busy_o,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (busy_q) begin
      if (ptr_q == LAST) busy_q <= 1'b0;
      else               ptr_q  <= ptr_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign ptr_o  = ptr_q;

  // R1: once done, stays done until reset
  a_r1_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> !busy_q);

  // R1: walk advances one word per cycle while busy
  a_r1_walk_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ptr_q != LAST) |=> (busy_q && ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/aw_mem_array.sv
module aw_mem_array #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 1024,
  parameter int IDX_W  = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int LANES = DATA_W / 8;

  // lane 0 holds the byte at the lowest address = most significant byte
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * b;
    logic [7:0] bank [WORDS];

    always_ff @(posedge clk_i) begin
      if (we_i) bank[widx_i] <= wdata_i[HI -: 8];
    end

    assign rdata_o[HI -: 8] = bank[ridx_i];
  end

  // R5: a written word is visible on the next cycle at the same index
  a_r5_write_visible: assert property (@(posedge clk_i)
    we_i |=> ((ridx_i == $past(widx_i)) -> (rdata_o == $past(wdata_i))));

endmodule

// File: rtl/aw_mem.sv
module aw_mem
  import aw_mem_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int MEM_BYTES = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_in_i,
  output logic [DATA_W-1:0] data_out_o,
  output logic              err_o,
  output logic              ready_o
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OFF_W      = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
  localparam int WORDS      = MEM_BYTES / WORD_BYTES;
  localparam int IDX_W      = $clog2(WORDS);

  mem_op_e           op;
  logic [IDX_W-1:0]  idx;
  logic              misalign;
  logic              busy;
  logic [IDX_W-1:0]  clr_ptr;
  logic              we;
  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;

  aw_mem_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_decode (
    .enable_i  (enable_i),
    .wr_i      (wr_i),
    .ready_i   (!busy),
    .addr_i    (addr_i),
    .op_o      (op),
    .idx_o     (idx),
    .misalign_o(misalign)
  );

  aw_mem_clear #(.WORDS(WORDS), .IDX_W(IDX_W)) u_clear (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_o(busy),
    .ptr_o (clr_ptr)
  );

  // clear walk owns the write port until done
  always_comb begin
    if (busy) begin
      we    = 1'b1;
      widx  = clr_ptr;
      wdata = '0;
    end else begin
      we    = (op == OP_WRITE);
      widx  = idx;
      wdata = data_in_i;
    end
  end

  aw_mem_array #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (we),
    .widx_i (widx),
    .wdata_i(wdata),
    .ridx_i (idx),
    .rdata_o(rdata)
  );

  assign data_out_o = (op == OP_READ) ? rdata : '0;
  assign err_o      = misalign;
  assign ready_o    = !busy;

  // R3: idle inputs give a quiet output
  a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (data_out_o == '0 && !err_o));

  // R10: nothing leaks out before the clear completes
  a_r10_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (data_out_o == '0 && !err_o));

  // R5: write cycles drive zero on the read port
  a_r5_write_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && wr_i) |-> (data_out_o == '0));

  // R6: error flag only during an enabled access
  a_r6_err_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (enable_i && ready_o));

endmodule

// File: tb/aw_mem_bench.sv
module aw_mem_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 64;
  localparam int WORDS      = MEM_BYTES / 2;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        en, wr;
  logic [15:0] addr, din;
  logic [15:0] dout;
  logic        err, ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  aw_mem #(.ADDR_W(16), .DATA_W(16), .MEM_BYTES(MEM_BYTES)) u_aw_mem (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .enable_i  (en),
    .wr_i      (wr),
    .addr_i    (addr),
    .data_in_i (din),
    .data_out_o(dout),
    .err_o     (err),
    .ready_o   (ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i, input int salt);
    return 16'(i * 16'h1357 + 16'h2468 + salt * 16'h0F0F);
  endfunction

  task automatic write_word(input logic [15:0] a, input logic [15:0] d, input string req);
    @(negedge clk);
    en = 1'b1; wr = 1'b1; addr = a; din = d;
    #1;
    check({req, " write data_out zero"}, 32'(dout), 32'h0);
    check({req, " write err"}, 32'(err), 32'(a[0]));
    @(posedge clk);
    #1;
    en = 1'b0; wr = 1'b0;
  endtask

  task automatic read_word(input logic [15:0] a, input logic [15:0] exp, input string req);
    en = 1'b1; wr = 1'b0; addr = a;
    #1;
    check({req, " read data"}, 32'(dout), 32'(exp));
    check({req, " read err"}, 32'(err), 32'(a[0]));
    en = 1'b0;
    #1;
  endtask

  task automatic wait_ready(output int cycles);
    cycles = 0;
    while (!ready && cycles < 4 * WORDS) begin
      @(posedge clk);
      #1;
      cycles++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    rst_ni = 1'b0; en = 1'b0; wr = 1'b0; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 / R10: reset state
    check("R1 ready low in reset", 32'(ready), 32'h0);
    check("R10 data_out zero in reset", 32'(dout), 32'h0);
    check("R10 err low in reset", 32'(err), 32'h0);

    @(negedge clk);
    rst_ni = 1'b1;
    wait_ready(cyc);
    check("R1 clear walk length", 32'(cyc), 32'(WORDS));

    // R2: all words clear
    for (int i = 0; i < WORDS; i++) read_word(16'(2 * i), 16'h0, "R2 cleared");

    // R5: fill every word
    for (int i = 0; i < WORDS; i++) write_word(16'(2 * i), pat(i, 0), "R5");

    // R4 / R6 / R7: every byte address
    for (int a = 0; a < MEM_BYTES; a++) read_word(16'(a), pat(a / 2, 0), "R7 sweep");

    // R4: flow-through without a clock edge
    @(negedge clk);
    en = 1'b1; wr = 1'b0; addr = 16'd4;
    #1 check("R4 flow first", 32'(dout), 32'(pat(2, 0)));
    addr = 16'd10;
    #1 check("R4 flow follows addr", 32'(dout), 32'(pat(5, 0)));
    addr = 16'd11;
    #1 check("R4 flow odd addr", 32'(dout), 32'(pat(5, 0)));
    check("R6 err odd", 32'(err), 32'h1);
    en = 1'b0;

    // R9: aliasing of high address bits
    read_word(16'(MEM_BYTES + 6), pat(3, 0), "R9 alias +64");
    read_word(16'hFFC0 + 16'd6, pat(3, 0), "R9 alias top");
    write_word(16'h8000 + 16'd8, 16'hC0DE, "R9");
    read_word(16'd8, 16'hC0DE, "R9 alias write");

    // R3: enable low with wr high does not write
    @(negedge clk);
    en = 1'b0; wr = 1'b1; addr = 16'd2; din = 16'hFFFF;
    #1;
    check("R3 idle data_out", 32'(dout), 32'h0);
    check("R3 idle err", 32'(err), 32'h0);
    @(posedge clk);
    #1 wr = 1'b0;
    read_word(16'd2, pat(1, 0), "R3 no write when idle");

    // R8: misaligned writes update the aligned word
    for (int i = 0; i < WORDS; i++) write_word(16'(2 * i + 1), pat(i, 1), "R8");
    for (int i = 0; i < WORDS; i++) read_word(16'(2 * i), pat(i, 1), "R8 aligned update");

    // R10 / R2: second reset with accesses during the walk
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      en = 1'b1; wr = (k != 3); addr = (k == 5) ? 16'd0 : 16'd1; din = 16'hBEEF;
      #1;
      check("R10 busy data_out", 32'(dout), 32'h0);
      check("R10 busy err", 32'(err), 32'h0);
      check("R1 busy ready low", 32'(ready), 32'h0);
    end
    @(negedge clk);
    en = 1'b0; wr = 1'b0;
    wait_ready(cyc);
    check("R1 ready after second reset", 32'(ready), 32'h1);
    read_word(16'd0, 16'h0, "R10 dropped write");
    for (int i = 0; i < WORDS; i++) read_word(16'(2 * i), 16'h0, "R2 cleared again");

    // R1: ready holds
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R1 ready holds", 32'(ready), 32'h1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule